// File: doc/BRIEF.md
# Synthesizer Frequency-Update Trigger Controller

This block is the digital control core between a register write port and a fractional-N divider with its sigma-delta phase accumulator. Software writes a primary integer/fractional divide pair, an alternate pair, an auxiliary step word, a 24-bit phase seed and a control word. The block keeps staged copies of these values and drives the active divide value and the active phase. The operating mode decides when and how staged values reach the active outputs.

The mode field selects one of these behaviours:
- Fractional and exact-frequency modes use buffered updates. The staged values are committed either by a trigger or by a fractional-register write.
- Integer mode is a direct path.
- FM mode selects between the two divide pairs by the trigger level.
- PM mode steps the phase on each trigger.
- Ramp mode walks the divide value from a start point to a stop point in fixed increments, one step per trigger.

A trigger comes from an external pin, passed through a synchronizer and gated by an enable bit, or from a software trigger bit. An optional autoseed loads the seed into the phase on a trigger.

Top module: `fnsyn_trig_ctrl`

## Requirements
- R1: After reset the mode is fractional (0), autoseed, external-trigger enable and the software trigger bit are clear, the active integer, fractional and phase outputs are zero, and ramp_done_o is low.
- R2: The control word written through wr_ctrl_i has these fields:
  - bits [2:0] select the mode;
  - bit 8 is autoseed;
  - bit 9 is the external-trigger enable;
  - bit 10 is the software trigger.

  The trigger level is the OR of the software bit and the synchronized pin ANDed with the enable. A trigger event is a rising edge of that level and lasts one cycle. The pin has no effect while the enable is clear.
- R3: In modes 0 and 2, while the external-trigger enable is set, writes to the integer and fractional registers do not change the active divide value until a trigger event commits both staged values.
- R4: In modes 0 and 2, while the external-trigger enable is clear, an integer write is held. The next fractional write commits the held integer value and the written fractional value together.
- R5: In mode 1, the active integer value follows the integer register within two cycles of a write, and the active fractional output is forced to zero. Fractional writes are ignored there.
- R6: In mode 3, the active divide value is the primary pair while the trigger level is low and the alternate pair while it is high.
- R7: In mode 4, each trigger event adds the 24-bit auxiliary word to the phase, modulo 2^24. A two's-complement word therefore steps the phase downward. The divide value holds.
- R8: In ramp mode, divider register writes do not change the active value. The first trigger loads the start value, which is the primary pair. Each later trigger adds the auxiliary word, zero-extended, to the combined {integer, fraction} value.
- R9: When a step would reach or pass the stop value (the alternate pair), the active value becomes the stop value and ramp_done_o goes high. The next trigger restarts from the start value and clears ramp_done_o. Leaving ramp mode clears ramp_done_o.
- R10: When autoseed is set, the 24-bit seed is loaded into the phase on the clock edge that ends a trigger event's cycle. When autoseed is clear, a trigger does not load the seed.
- R11: Mode values 5, 6 and 7 all select ramp mode.
- R12: The phase output changes only on a trigger event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_data_i | input | 24 | Write data shared by all register strobes |
| wr_int_i | input | 1 | Write primary integer register |
| wr_frac_i | input | 1 | Write primary fractional register |
| wr_aux_i | input | 1 | Write auxiliary step register |
| wr_alt_int_i | input | 1 | Write alternate integer register |
| wr_alt_frac_i | input | 1 | Write alternate fractional register |
| wr_seed_i | input | 1 | Write phase seed register |
| wr_ctrl_i | input | 1 | Write control word (mode, autoseed, enable, software trigger) |
| trig_pin_i | input | 1 | Asynchronous external trigger pin |
| act_int_o | output | 16 | Active integer divide value |
| act_frac_o | output | 24 | Active fractional divide value |
| phase_o | output | 24 | Active modulator phase |
| ramp_done_o | output | 1 | Ramp has reached its stop value |

## Verification
The assertions check the following on every cycle:
- the trigger pulse lasts one cycle;
- the active value stays frozen in buffered modes between triggers;
- the fraction is zero in integer mode;
- the FM selection follows the trigger level;
- the seed loads when autoseed is set;
- the phase holds without a trigger;
- the ramp lands exactly on the stop value when done rises.

Only the directed scenarios can show the sequence behaviours:
- the integer-then-fraction pairing with the enable clear;
- the pin being ignored while disabled;
- the exact ramp trajectory and its restart;
- the downward phase step by a two's-complement word.

// File: rtl/fnsyn_pkg.sv
package fnsyn_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_FRAC  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_INT   = 3'd1;
  localparam logic [MODE_W-1:0] MODE_EXACT = 3'd2;
  localparam logic [MODE_W-1:0] MODE_FM    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_PM    = 3'd4;
  localparam logic [MODE_W-1:0] MODE_RAMP0 = 3'd5;

  localparam int CTRL_AUTOSEED_BIT = 8;
  localparam int CTRL_EXT_EN_BIT   = 9;
  localparam int CTRL_SW_TRIG_BIT  = 10;

  function automatic logic is_ramp(input logic [MODE_W-1:0] m);
    return m >= MODE_RAMP0;
  endfunction

  function automatic logic is_buffered(input logic [MODE_W-1:0] m);
    return (m == MODE_FRAC) || (m == MODE_EXACT);
  endfunction
endpackage

// File: rtl/fnsyn_trig_detect.sv
module fnsyn_trig_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic ext_en_i,
  input  logic sw_i,
  output logic level_o,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign level_o = (sync_q[SYNC_STAGES-1] & ext_en_i) | sw_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_o;

  assign pulse_o = level_o & ~prev_q;
endmodule

// File: rtl/fnsyn_ramp_next.sv
module fnsyn_ramp_next #(
  parameter int VAL_W  = 40,
  parameter int STEP_W = 24
) (
  input  logic [VAL_W-1:0]  cur_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [VAL_W-1:0]  stop_i,
  output logic [VAL_W-1:0]  next_o,
  output logic              hit_o
);
  localparam int PAD_W = VAL_W + 1 - STEP_W;

  logic [VAL_W:0] sum;

  assign sum    = {1'b0, cur_i} + {{PAD_W{1'b0}}, step_i};
  assign next_o = sum[VAL_W-1:0];
  // carry out counts as passing the stop point
  assign hit_o  = sum[VAL_W] | (sum[VAL_W-1:0] >= stop_i);
endmodule

// File: rtl/fnsyn_phase_unit.sv
module fnsyn_phase_unit #(
  parameter int PH_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic            autoseed_i,
  input  logic            pm_en_i,
  input  logic [PH_W-1:0] seed_i,
  input  logic [PH_W-1:0] step_i,
  output logic [PH_W-1:0] phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  phase_o <= '0;
    else if (trig_i && autoseed_i) phase_o <= seed_i;
    else if (trig_i && pm_en_i)    phase_o <= phase_o + step_i;
endmodule

// File: rtl/fnsyn_trig_ctrl.sv
module fnsyn_trig_ctrl
  import fnsyn_pkg::*;
#(
  parameter int INT_W       = 16,
  parameter int FRAC_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] wr_data_i,
  input  logic              wr_int_i,
  input  logic              wr_frac_i,
  input  logic              wr_aux_i,
  input  logic              wr_alt_int_i,
  input  logic              wr_alt_frac_i,
  input  logic              wr_seed_i,
  input  logic              wr_ctrl_i,
  input  logic              trig_pin_i,
  output logic [INT_W-1:0]  act_int_o,
  output logic [FRAC_W-1:0] act_frac_o,
  output logic [FRAC_W-1:0] phase_o,
  output logic              ramp_done_o
);
  localparam int VAL_W = INT_W + FRAC_W;

  logic [MODE_W-1:0] mode_q;
  logic              autoseed_q, ext_en_q, sw_q;

  logic [INT_W-1:0]  int_s, alt_int_s;
  logic [FRAC_W-1:0] frac_s, alt_frac_s, aux_s, seed_s;

  logic              trig_lvl, trig_pulse;
  logic              ramp_run_q;
  logic [VAL_W-1:0]  ramp_next;
  logic              ramp_hit;
  logic [VAL_W-1:0]  start_val, stop_val, act_val;

  // control word
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode_q     <= MODE_FRAC;
      autoseed_q <= 1'b0;
      ext_en_q   <= 1'b0;
      sw_q       <= 1'b0;
    end else if (wr_ctrl_i) begin
      mode_q     <= wr_data_i[MODE_W-1:0];
      autoseed_q <= wr_data_i[CTRL_AUTOSEED_BIT];
      ext_en_q   <= wr_data_i[CTRL_EXT_EN_BIT];
      sw_q       <= wr_data_i[CTRL_SW_TRIG_BIT];
    end

  // staging registers, written in every mode
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      int_s      <= '0;
      frac_s     <= '0;
      alt_int_s  <= '0;
      alt_frac_s <= '0;
      aux_s      <= '0;
      seed_s     <= '0;
    end else begin
      if (wr_int_i)      int_s      <= wr_data_i[INT_W-1:0];
      if (wr_frac_i)     frac_s     <= wr_data_i;
      if (wr_alt_int_i)  alt_int_s  <= wr_data_i[INT_W-1:0];
      if (wr_alt_frac_i) alt_frac_s <= wr_data_i;
      if (wr_aux_i)      aux_s      <= wr_data_i;
      if (wr_seed_i)     seed_s     <= wr_data_i;
    end

  fnsyn_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (trig_pin_i),
    .ext_en_i (ext_en_q),
    .sw_i     (sw_q),
    .level_o  (trig_lvl),
    .pulse_o  (trig_pulse)
  );

  assign start_val = {int_s, frac_s};
  assign stop_val  = {alt_int_s, alt_frac_s};
  assign act_val   = {act_int_o, act_frac_o};

  fnsyn_ramp_next #(.VAL_W(VAL_W), .STEP_W(FRAC_W)) u_ramp (
    .cur_i  (act_val),
    .step_i (aux_s),
    .stop_i (stop_val),
    .next_o (ramp_next),
    .hit_o  (ramp_hit)
  );

  // active divide value
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      act_int_o   <= '0;
      act_frac_o  <= '0;
      ramp_run_q  <= 1'b0;
      ramp_done_o <= 1'b0;
    end else begin
      if (!is_ramp(mode_q)) begin
        ramp_run_q  <= 1'b0;
        ramp_done_o <= 1'b0;
      end
      case (mode_q)
        MODE_FRAC, MODE_EXACT: begin
          if (trig_pulse) begin
            act_int_o  <= int_s;
            act_frac_o <= frac_s;
          end else if (!ext_en_q && wr_frac_i) begin
            act_int_o  <= int_s;
            act_frac_o <= wr_data_i;
          end
        end
        MODE_INT: begin
          act_int_o  <= int_s;
          act_frac_o <= '0;
        end
        MODE_FM: begin
          if (trig_lvl) {act_int_o, act_frac_o} <= stop_val;
          else          {act_int_o, act_frac_o} <= start_val;
        end
        MODE_PM: ;
        default: begin
          if (trig_pulse) begin
            if (!ramp_run_q || ramp_done_o) begin
              {act_int_o, act_frac_o} <= start_val;
              ramp_run_q  <= 1'b1;
              ramp_done_o <= 1'b0;
            end else if (ramp_hit) begin
              {act_int_o, act_frac_o} <= stop_val;
              ramp_done_o <= 1'b1;
            end else begin
              {act_int_o, act_frac_o} <= ramp_next;
            end
          end
        end
      endcase
    end

  fnsyn_phase_unit #(.PH_W(FRAC_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_pulse),
    .autoseed_i (autoseed_q),
    .pm_en_i    (mode_q == MODE_PM),
    .seed_i     (seed_s),
    .step_i     (aux_s),
    .phase_o    (phase_o)
  );
endmodule

// File: rtl/fnsyn_trig_ctrl_chk.sv
module fnsyn_trig_ctrl_chk
  import fnsyn_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_q,
  input logic              ext_en_q,
  input logic              autoseed_q,
  input logic              wr_ctrl_i,
  input logic              trig_pulse,
  input logic              trig_lvl,
  input logic [INT_W-1:0]  int_s,
  input logic [FRAC_W-1:0] frac_s,
  input logic [INT_W-1:0]  alt_int_s,
  input logic [FRAC_W-1:0] alt_frac_s,
  input logic [FRAC_W-1:0] seed_s,
  input logic [INT_W-1:0]  act_int_o,
  input logic [FRAC_W-1:0] act_frac_o,
  input logic [FRAC_W-1:0] phase_o,
  input logic              ramp_done_o
);
  AST_TRIG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_pulse |=> !trig_pulse); // R2

  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_buffered(mode_q) && ext_en_q && !trig_pulse && !wr_ctrl_i)
      |=> ($stable(act_int_o) && $stable(act_frac_o))); // R3

  AST_INT_FRAC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_INT && !wr_ctrl_i) |=> (act_frac_o == '0)); // R5

  AST_FM_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FM) |=>
      ({act_int_o, act_frac_o} == ($past(trig_lvl) ? $past({alt_int_s, alt_frac_s})
                                                    : $past({int_s, frac_s})))); // R6

  AST_RAMP_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ramp_done_o) |-> ({act_int_o, act_frac_o} == $past({alt_int_s, alt_frac_s}))); // R9

  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_ramp(mode_q) |=> !ramp_done_o); // R9

  AST_SEED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_pulse && autoseed_q) |=> (phase_o == $past(seed_s))); // R10

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_pulse |=> $stable(phase_o)); // R12
endmodule

bind fnsyn_trig_ctrl fnsyn_trig_ctrl_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_q      (mode_q),
  .ext_en_q    (ext_en_q),
  .autoseed_q  (autoseed_q),
  .wr_ctrl_i   (wr_ctrl_i),
  .trig_pulse  (trig_pulse),
  .trig_lvl    (trig_lvl),
  .int_s       (int_s),
  .frac_s      (frac_s),
  .alt_int_s   (alt_int_s),
  .alt_frac_s  (alt_frac_s),
  .seed_s      (seed_s),
  .act_int_o   (act_int_o),
  .act_frac_o  (act_frac_o),
  .phase_o     (phase_o),
  .ramp_done_o (ramp_done_o)
);

// File: tb/fnsyn_trig_ctrl_tb.sv
module fnsyn_trig_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EN  = 1 << 9;
  localparam int SW  = 1 << 10;
  localparam int AS  = 1 << 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] wr_data = '0;
  logic        wr_int = 0, wr_frac = 0, wr_aux = 0, wr_alt_int = 0;
  logic        wr_alt_frac = 0, wr_seed = 0, wr_ctrl = 0, pin = 0;
  logic [15:0] act_int;
  logic [23:0] act_frac, phase;
  logic        ramp_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fnsyn_trig_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_data_i(wr_data),
    .wr_int_i(wr_int), .wr_frac_i(wr_frac), .wr_aux_i(wr_aux),
    .wr_alt_int_i(wr_alt_int), .wr_alt_frac_i(wr_alt_frac),
    .wr_seed_i(wr_seed), .wr_ctrl_i(wr_ctrl), .trig_pin_i(pin),
    .act_int_o(act_int), .act_frac_o(act_frac), .phase_o(phase),
    .ramp_done_o(ramp_done)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // kind: 0 int 1 frac 2 aux 3 alt_int 4 alt_frac 5 seed 6 ctrl
  task automatic wr(input int kind, input logic [23:0] d);
    @(negedge clk);
    wr_data = d;
    case (kind)
      0: wr_int = 1;
      1: wr_frac = 1;
      2: wr_aux = 1;
      3: wr_alt_int = 1;
      4: wr_alt_frac = 1;
      5: wr_seed = 1;
      default: wr_ctrl = 1;
    endcase
    @(negedge clk);
    {wr_int, wr_frac, wr_aux, wr_alt_int, wr_alt_frac, wr_seed, wr_ctrl} = '0;
  endtask

  task automatic pin_pulse();
    @(negedge clk);
    pin = 1;
    cyc(4);
    pin = 0;
    cyc(3);
  endtask

  task automatic t_reset();
    chk("R1 int", act_int, 0);
    chk("R1 frac", act_frac, 0);
    chk("R1 phase", phase, 0);
    chk("R1 done", ramp_done, 0);
  endtask

  task automatic t_buffered();
    wr(6, EN);
    wr(0, 24'd5);
    wr(1, 24'h123456);
    cyc(4);
    chk("R3 held", {act_int, act_frac}, 0);
    pin_pulse();
    chk("R3 R2 pin commit", {act_int, act_frac}, {16'd5, 24'h123456});
    wr(6, EN | 2);
    wr(0, 24'd7);
    wr(1, 24'h10);
    cyc(3);
    chk("R3 exact held", {act_int, act_frac}, {16'd5, 24'h123456});
    wr(6, SW | EN | 2);
    cyc(3);
    chk("R2 R3 sw commit", {act_int, act_frac}, {16'd7, 24'h10});
    wr(6, EN | 2);
  endtask

  task automatic t_unbuffered();
    wr(6, 0);
    wr(0, 24'd9);
    pin_pulse();
    chk("R2 R4 pin ignored, int held", {act_int, act_frac}, {16'd7, 24'h10});
    wr(1, 24'h2000);
    cyc(2);
    chk("R4 frac write commits", {act_int, act_frac}, {16'd9, 24'h2000});
  endtask

  task automatic t_integer();
    wr(6, 1);
    wr(0, 24'd33);
    cyc(2);
    chk("R5 int direct", {act_int, act_frac}, {16'd33, 24'h0});
    wr(1, 24'h55);
    cyc(2);
    chk("R5 frac ignored", act_frac, 0);
  endtask

  task automatic t_fm();
    wr(3, 24'd40);
    wr(4, 24'h800);
    wr(6, EN | 3);
    cyc(3);
    chk("R6 low", {act_int, act_frac}, {16'd33, 24'h55});
    pin = 1;
    cyc(4);
    chk("R6 high", {act_int, act_frac}, {16'd40, 24'h800});
    pin = 0;
    cyc(4);
    chk("R6 back low", {act_int, act_frac}, {16'd33, 24'h55});
  endtask

  task automatic t_pm();
    wr(6, EN | 4);
    wr(2, 24'h000100);
    pin_pulse();
    pin_pulse();
    chk("R7 up two steps", phase, 24'h200);
    chk("R7 divide holds", {act_int, act_frac}, {16'd33, 24'h55});
    wr(2, 24'hFFFF00);
    pin_pulse();
    chk("R7 down step", phase, 24'h100);
    cyc(5);
    chk("R12 hold", phase, 24'h100);
  endtask

  task automatic t_seed();
    wr(6, EN | AS);
    wr(5, 24'h333333);
    cyc(3);
    chk("R12 seed write no effect", phase, 24'h100);
    pin_pulse();
    chk("R10 seed load", phase, 24'h333333);
    wr(6, EN);
    wr(5, 24'h111111);
    pin_pulse();
    chk("R10 no autoseed", phase, 24'h333333);
  endtask

  task automatic t_ramp();
    wr(6, EN | 7);
    wr(0, 24'd10);
    wr(1, 24'h0);
    wr(3, 24'd10);
    wr(4, 24'h280000);
    wr(2, 24'h100000);
    cyc(2);
    chk("R8 R11 writes not direct", {act_int, act_frac}, {16'd33, 24'h55});
    pin_pulse();
    chk("R8 start", {act_int, act_frac}, {16'd10, 24'h0});
    pin_pulse();
    chk("R8 step1", {act_int, act_frac}, {16'd10, 24'h100000});
    pin_pulse();
    chk("R8 step2", {act_int, act_frac}, {16'd10, 24'h200000});
    chk("R9 not done", ramp_done, 0);
    pin_pulse();
    chk("R9 clamp stop", {act_int, act_frac}, {16'd10, 24'h280000});
    chk("R9 done", ramp_done, 1);
    pin_pulse();
    chk("R9 restart", {act_int, act_frac}, {16'd10, 24'h0});
    chk("R9 done cleared", ramp_done, 0);
    wr(6, EN | 5);
    pin_pulse();
    chk("R11 mode5 ramp step", {act_int, act_frac}, {16'd10, 24'h100000});
    wr(6, EN | 4);
    cyc(2);
    chk("R9 leave clears", ramp_done, 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1;
    cyc(2);
    t_reset();
    t_buffered();
    t_unbuffered();
    t_integer();
    t_fm();
    t_pm();
    t_seed();
    t_ramp();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule